// File: doc/BRIEF.md
# Ternary Content-Addressable Match Array

This block stores a table of ternary entries and compares a search key against every entry at once. Each bit of an entry is held as a two-rail pair. A stored one is kept as (1,0). A stored zero is kept as (0,1). The pair (0,0) marks a don't-care bit, and that bit plays no part in the comparison. Software writes an entry through the write port as a data word together with a care mask. A cleared care bit turns the matching data bit into a don't-care. Each row also carries a valid flag. A row whose flag is clear never matches.

A search request is registered. One clock later the block presents a per-row match vector, the index of the lowest matching row and a hit flag. These results stay until the next request. A power-down input stops evaluation and blanks the results, and the stored table is kept. A serial test chain can drive every input bit and capture every output bit, so the full-size array can be tested through four pins.

Top module: `tcam_array`

## Requirements
- R1: A write stores bit b of the entry as the pair (data[b], !data[b]) when care[b] is 1, and as (0,0) when care[b] is 0. A (0,0) bit matches either key value.
- R2: A valid row matches when, for every bit whose care bit was set at its last write, the key bit equals the stored data bit.
- R3: A valid row written with an all-zero care mask matches every key.
- R4: After reset every row is invalid, and the match vector, the index and the hit flag are all zero. A search made before any write returns no hit.
- R5: The results of a request taken at a clock edge appear after that edge and are held unchanged until the next request or power-down.
- R6: The hit flag is 1 when any bit of the match vector is set. The index is the lowest set position. When there is no hit the index is 0.
- R7: When a write and a search reach the same row at the same edge, the search sees the row's old contents. The new entry takes effect from the next edge.
- R8: While power-down is high, the match vector and the hit flag are zero and requests are dropped. After power-down ends, the outputs stay zero until the next request, and that request sees the contents that were stored before.
- R9: A write with the valid input at 0 invalidates the row, so the row no longer matches any key.
- R10: In test mode, the input segment of the chain holds the bit fields, from the LSB up: address, data, care, valid, write enable, key, request, power-down. A rising update strobe applies that segment as one operation. Two edges later the output segment (match vector at bit 0, then the index, then hit) captures the results. The chain shifts toward the serial output, which shows bit 0 of the chain.
- R11: While test mode is high, the parallel write and search inputs have no effect on the table or on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Row to write |
| wr_data | input | WIDTH | Entry data |
| wr_care | input | WIDTH | Care mask; 0 makes the bit don't-care |
| wr_valid | input | 1 | Valid flag written with the entry |
| srch_req | input | 1 | Search request |
| srch_key | input | WIDTH | Search key |
| pwr_down | input | 1 | Stops evaluation and blanks results |
| match_vec | output | ROWS | Per-row match result |
| first_idx | output | AW | Lowest matching row |
| any_hit | output | 1 | At least one row matched |
| tst_mode | input | 1 | Selects the chain as the input source |
| tst_si | input | 1 | Serial chain input |
| tst_shift | input | 1 | Shift enable |
| tst_update | input | 1 | Apply / capture strobe |
| tst_so | output | 1 | Serial chain output |

## Verification
The bench uses a 16-row, 4-bit array. It fills the table with full, partial, empty and invalid masks, then checks every key against a model of that table. A wrong rail code or wrong don't-care handling shows up as a wrong match bit for some key. A priority encoder that scans upward from the wrong end returns a higher index than the model. The bench writes and searches one row at the same edge. A design that forwards the new data returns a hit that the model does not expect. The bench also raises power-down and makes a request while it is high. A design that keeps evaluating shows a stale or fresh hit during power-down or just after it. Operations through the test chain are compared bit by bit, so a chain that is misordered or captures at the wrong time reads back a shifted or stale result.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  // Two-rail cell code: {hi, lo}; 10 = one, 01 = zero, 00 = don't-care.
  function automatic logic [1:0] cell_code(input logic d, input logic care);
    return care ? {d, ~d} : 2'b00;
  endfunction

  // A cell agrees with key bit k when it is don't-care or its rail matches.
  function automatic logic cell_agrees(input logic hi, input logic lo, input logic k);
    return (~hi & ~lo) | (hi & k) | (lo & ~k);
  endfunction
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int ROWS  = 512,
  parameter int WIDTH = 18,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] care,
  input  logic             set_valid,
  output logic [WIDTH-1:0] row_hi [ROWS],
  output logic [WIDTH-1:0] row_lo [ROWS],
  output logic [ROWS-1:0]  valid
);
  import tcam_pkg::*;

  logic [WIDTH-1:0] hi_mem [ROWS];
  logic [WIDTH-1:0] lo_mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < WIDTH; b++)
        {hi_mem[addr][b], lo_mem[addr][b]} <= cell_code(data[b], care[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else if (we) valid[addr] <= set_valid;
  end

  assign row_hi = hi_mem;
  assign row_lo = lo_mem;

  // R1: stored rails follow data and care of the last write
  a_r1_code_hi: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (hi_mem[$past(addr)] == ($past(data) & $past(care))));
  a_r1_code_lo: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (lo_mem[$past(addr)] == (~$past(data) & $past(care))));
  // R9: an invalidating write clears the row's flag
  a_r9_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !set_valid) |=> !valid[$past(addr)]);
endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
  parameter int ROWS  = 512,
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             pd,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] row_hi [ROWS],
  input  logic [WIDTH-1:0] row_lo [ROWS],
  input  logic [ROWS-1:0]  valid,
  output logic [ROWS-1:0]  match_vec
);
  import tcam_pkg::*;

  logic [ROWS-1:0] raw_match;
  logic [ROWS-1:0] match_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_comb begin
      raw_match[r] = valid[r];
      for (int b = 0; b < WIDTH; b++)
        raw_match[r] = raw_match[r] & cell_agrees(row_hi[r][b], row_lo[r][b], key[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   match_q <= '0;
    else if (pd)  match_q <= '0;
    else if (req) match_q <= raw_match;
  end

  assign match_vec = pd ? '0 : match_q;

  // R5: results hold while no request and no power-down
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !pd) |=> $stable(match_q));
  // R8: power-down leaves nothing behind
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (match_q == '0));
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int ROWS = 512,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] vec,
  output logic [AW-1:0]   idx,
  output logic            hit
);
  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = AW'(i);
        hit = 1'b1;
      end
    end
  end

  // R6: the reported row is set and nothing below it is
  a_r6_selected: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> vec[idx]);
  a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((vec & ((ROWS'(1) << idx) - ROWS'(1))) == '0));
  a_r6_idle_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (idx == '0));
endmodule

// File: rtl/tcam_scan.sv
module tcam_scan #(
  parameter int IN_W  = 67,
  parameter int OUT_W = 522,
  localparam int N    = IN_W + OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             si,
  input  logic             shift,
  input  logic             update,
  input  logic [OUT_W-1:0] par_out,
  output logic             so,
  output logic [IN_W-1:0]  shadow,
  output logic             fire
);
  logic [N-1:0] chain;
  logic         upd_d;
  logic         cap;
  logic         upd_rise;

  assign upd_rise = update & ~upd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      shadow <= '0;
      upd_d  <= 1'b0;
      fire   <= 1'b0;
      cap    <= 1'b0;
    end else begin
      upd_d <= update;
      fire  <= upd_rise;
      cap   <= fire;
      if (upd_rise) shadow <= chain[N-1:OUT_W];
      if (shift)    chain <= {si, chain[N-1:1]};
      else if (cap) chain[OUT_W-1:0] <= par_out;
    end
  end

  assign so = chain[0];

  // R10: one operation per strobe, capture two edges later
  a_r10_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !shift) |=> (chain[OUT_W-1:0] == $past(par_out)));
endmodule

// File: rtl/tcam_array.sv
module tcam_array #(
  parameter int ROWS  = 512,
  parameter int WIDTH = 18,
  localparam int AW    = $clog2(ROWS),
  localparam int IN_W  = AW + 3 * WIDTH + 4,
  localparam int OUT_W = ROWS + AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_care,
  input  logic             wr_valid,
  input  logic             srch_req,
  input  logic [WIDTH-1:0] srch_key,
  input  logic             pwr_down,
  output logic [ROWS-1:0]  match_vec,
  output logic [AW-1:0]    first_idx,
  output logic             any_hit,
  input  logic             tst_mode,
  input  logic             tst_si,
  input  logic             tst_shift,
  input  logic             tst_update,
  output logic             tst_so
);
  logic [IN_W-1:0]  shadow;
  logic             fire;
  logic             core_we, core_valid, core_req, core_pd;
  logic [AW-1:0]    core_addr;
  logic [WIDTH-1:0] core_data, core_care, core_key;
  logic [WIDTH-1:0] row_hi [ROWS];
  logic [WIDTH-1:0] row_lo [ROWS];
  logic [ROWS-1:0]  valid;

  always_comb begin
    if (tst_mode) begin
      core_addr  = shadow[AW-1:0];
      core_data  = shadow[AW +: WIDTH];
      core_care  = shadow[AW+WIDTH +: WIDTH];
      core_valid = shadow[AW+2*WIDTH];
      core_we    = shadow[AW+2*WIDTH+1] & fire;
      core_key   = shadow[AW+2*WIDTH+2 +: WIDTH];
      core_req   = shadow[AW+3*WIDTH+2] & fire;
      core_pd    = shadow[AW+3*WIDTH+3];
    end else begin
      core_addr  = wr_addr;
      core_data  = wr_data;
      core_care  = wr_care;
      core_valid = wr_valid;
      core_we    = wr_en;
      core_key   = srch_key;
      core_req   = srch_req;
      core_pd    = pwr_down;
    end
  end

  tcam_store #(.ROWS(ROWS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(core_we), .addr(core_addr),
    .data(core_data), .care(core_care), .set_valid(core_valid),
    .row_hi(row_hi), .row_lo(row_lo), .valid(valid));

  tcam_match #(.ROWS(ROWS), .WIDTH(WIDTH)) u_match (
    .clk(clk), .rst_n(rst_n), .req(core_req), .pd(core_pd), .key(core_key),
    .row_hi(row_hi), .row_lo(row_lo), .valid(valid), .match_vec(match_vec));

  tcam_prio #(.ROWS(ROWS)) u_prio (
    .clk(clk), .rst_n(rst_n), .vec(match_vec), .idx(first_idx), .hit(any_hit));

  tcam_scan #(.IN_W(IN_W), .OUT_W(OUT_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .si(tst_si), .shift(tst_shift), .update(tst_update),
    .par_out({any_hit, first_idx, match_vec}), .so(tst_so),
    .shadow(shadow), .fire(fire));

  // R8: no result is visible during power-down
  a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
    core_pd |-> (match_vec == '0 && !any_hit));
  // R11: test mode blocks parallel writes from reaching the table
  a_r11_no_par_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_mode && !fire) |-> !core_we);
endmodule

// File: tb/tcam_array_bench.sv
module tcam_array_bench;
  localparam int ROWS  = 16;
  localparam int WIDTH = 4;
  localparam int AW    = 4;
  localparam int IN_W  = AW + 3 * WIDTH + 4;
  localparam int OUT_W = ROWS + AW + 1;
  localparam int N     = IN_W + OUT_W;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_valid = 0, srch_req = 0, pwr_down = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0, wr_care = '0, srch_key = '0;
  logic [ROWS-1:0] match_vec;
  logic [AW-1:0] first_idx;
  logic any_hit;
  logic tst_mode = 0, tst_si = 0, tst_shift = 0, tst_update = 0;
  logic tst_so;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [WIDTH-1:0] m_data [ROWS];
  logic [WIDTH-1:0] m_care [ROWS];
  logic             m_valid [ROWS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tcam_array #(.ROWS(ROWS), .WIDTH(WIDTH)) u_tcam_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_care(wr_care), .wr_valid(wr_valid),
    .srch_req(srch_req), .srch_key(srch_key), .pwr_down(pwr_down),
    .match_vec(match_vec), .first_idx(first_idx), .any_hit(any_hit),
    .tst_mode(tst_mode), .tst_si(tst_si), .tst_shift(tst_shift),
    .tst_update(tst_update), .tst_so(tst_so));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ROWS-1:0] exp_vec(input logic [WIDTH-1:0] key);
    logic [ROWS-1:0] v;
    for (int r = 0; r < ROWS; r++)
      v[r] = m_valid[r] && (((key ^ m_data[r]) & m_care[r]) == '0);
    return v;
  endfunction

  function automatic logic [AW-1:0] exp_idx(input logic [ROWS-1:0] v);
    for (int r = 0; r < ROWS; r++) if (v[r]) return AW'(r);
    return '0;
  endfunction

  task automatic write_row(input int r, input logic [WIDTH-1:0] d,
                           input logic [WIDTH-1:0] c, input logic v);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(r); wr_data = d; wr_care = c; wr_valid = v;
    @(negedge clk);
    wr_en = 0;
    m_data[r] = d; m_care[r] = c; m_valid[r] = v;
  endtask

  task automatic search(input logic [WIDTH-1:0] key);
    @(negedge clk);
    srch_req = 1; srch_key = key;
    @(negedge clk);
    srch_req = 0;
  endtask

  task automatic check_result(input string tag, input logic [WIDTH-1:0] key);
    logic [ROWS-1:0] ev;
    ev = exp_vec(key);
    chk({tag, " vec"}, 64'(match_vec), 64'(ev));
    chk({tag, " idx"}, 64'(first_idx), 64'(exp_idx(ev)));
    chk({tag, " hit"}, 64'(any_hit), 64'(|ev));
  endtask

  function automatic logic [IN_W-1:0] pack_in(input int a, input logic [WIDTH-1:0] d,
      input logic [WIDTH-1:0] c, input logic v, input logic we,
      input logic [WIDTH-1:0] k, input logic rq, input logic pd);
    return {pd, rq, k, we, v, c, d, AW'(a)};
  endfunction

  task automatic chain_op(input logic [IN_W-1:0] inv, output logic [OUT_W-1:0] prev);
    logic [N-1:0] v;
    logic [N-1:0] got;
    v = {inv, {OUT_W{1'b0}}};
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      got[i] = tst_so;
      tst_si = v[i];
      tst_shift = 1;
    end
    @(negedge clk);
    tst_shift = 0; tst_update = 1;
    @(negedge clk);
    tst_update = 0;
    @(negedge clk);
    @(negedge clk);
    prev = got[OUT_W-1:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [OUT_W-1:0] rd;
    logic [ROWS-1:0] held;
    for (int r = 0; r < ROWS; r++) begin m_data[r] = '0; m_care[r] = '0; m_valid[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4: reset state and empty search
    chk("R4 reset vec", 64'(match_vec), 0);
    chk("R4 reset idx", 64'(first_idx), 0);
    chk("R4 reset hit", 64'(any_hit), 0);
    search(4'h5);
    chk("R4 empty search hit", 64'(any_hit), 0);

    // Table: full, upper-half and lower-half masks; row 13 all don't-care (R3); row 15 invalid
    for (int r = 0; r < ROWS; r++) begin
      logic [WIDTH-1:0] c;
      c = (r % 3 == 0) ? 4'hF : (r % 3 == 1) ? 4'hC : 4'h3;
      if (r == 13) c = 4'h0;
      write_row(r, WIDTH'((r * 5 + 3) & 15), c, r != 15);
    end

    // R1 R2 R3 R6: every key against the model
    for (int k = 0; k < 16; k++) begin
      search(WIDTH'(k));
      check_result("R1 R2 R3 R6 sweep", WIDTH'(k));
    end

    // R5: results held without a request
    search(4'h3);
    held = match_vec;
    repeat (4) @(negedge clk);
    chk("R5 hold vec", 64'(match_vec), 64'(held));
    check_result("R5 hold", 4'h3);

    // R7: same-edge write and search on row 0 see old contents
    @(negedge clk);
    wr_en = 1; wr_addr = 0; wr_data = 4'hE; wr_care = 4'hF; wr_valid = 1;
    srch_req = 1; srch_key = m_data[0];
    @(negedge clk);
    wr_en = 0; srch_req = 0;
    chk("R7 old row0 bit", 64'(match_vec[0]), 1);
    check_result("R7 old", m_data[0]);
    m_data[0] = 4'hE; m_care[0] = 4'hF; m_valid[0] = 1;
    search(4'hE);
    chk("R7 new row0 bit", 64'(match_vec[0]), 1);
    check_result("R7 new", 4'hE);

    // R9: invalidate the don't-care row
    write_row(13, 4'h0, 4'h0, 0);
    search(4'h7);
    chk("R9 invalid row13", 64'(match_vec[13]), 0);
    check_result("R9", 4'h7);

    // R8: power-down blanks, drops requests, keeps contents
    search(4'hE);
    @(negedge clk);
    pwr_down = 1;
    #1;
    chk("R8 pd vec", 64'(match_vec), 0);
    chk("R8 pd hit", 64'(any_hit), 0);
    search(4'hE);
    chk("R8 pd request dropped", 64'(any_hit), 0);
    @(negedge clk);
    pwr_down = 0;
    @(negedge clk);
    chk("R8 after pd vec", 64'(match_vec), 0);
    search(4'hE);
    check_result("R8 kept", 4'hE);

    // R11: parallel inputs ignored in test mode
    @(negedge clk);
    tst_mode = 1;
    @(negedge clk);
    wr_en = 1; wr_addr = 4; wr_data = 4'h9; wr_care = 4'hF; wr_valid = 1;
    srch_req = 1; srch_key = 4'h9;
    @(negedge clk);
    wr_en = 0; srch_req = 0;
    @(negedge clk);
    chk("R11 results unchanged", 64'(match_vec), 64'(exp_vec(4'hE)));

    // R10: chain operations; write row 2 then search its value
    chain_op(pack_in(2, 4'h9, 4'hF, 1, 1, 4'h0, 0, 0), rd);
    m_data[2] = 4'h9; m_care[2] = 4'hF; m_valid[2] = 1;
    chain_op(pack_in(0, 4'h0, 4'h0, 0, 0, 4'h9, 1, 0), rd);
    chk("R10 parallel view vec", 64'(match_vec), 64'(exp_vec(4'h9)));
    chain_op(pack_in(0, 4'h0, 4'h0, 0, 0, 4'h0, 0, 0), rd);
    chk("R10 chain vec", 64'(rd[ROWS-1:0]), 64'(exp_vec(4'h9)));
    chk("R10 chain idx", 64'(rd[ROWS +: AW]), 64'(exp_idx(exp_vec(4'h9))));
    chk("R10 chain hit", 64'(rd[OUT_W-1]), 64'(|exp_vec(4'h9)));

    // R11: row 4 still holds its earlier entry
    @(negedge clk);
    tst_mode = 0;
    search(4'h9);
    check_result("R11 row4 untouched", 4'h9);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule